// File: doc/BRIEF.md
# APB UART Register Front-End

This block is the register side of a UART, seen by software as a small memory-mapped window on an APB bus. Incoming bytes from a receiver are stored in a receive buffer and read out one at a time through the data register. A byte written to the data register is handed to a transmitter as a one-cycle valid strobe with the byte beside it. A status word reports buffer state and a sticky overrun flag. A control word enables each direction and its interrupt. The single interrupt output pulses for one cycle on each stored receive byte or sent transmit byte when the matching enable is set.

Bit timing, baud generation, parity, break detection and flow control live elsewhere. Their control bits are kept and read back but act on nothing here. The receive buffer is a linear store. It fills from slot zero and returns to slot zero only when it has been read empty, so slots freed by partial reads cannot be written again until then. The APB slave always completes in zero wait states and never signals an error.

Top module: `uart_apb_regs`

## Requirements
- R1: After reset the status word reads 0x006, the control word reads 0, the buffer is empty, rx_ready_o is high and irq_o and tx_valid_o are low.
- R2: The control word at offset 0x08 reads back exactly the last 32-bit value written to it. Writes to the status word at offset 0x04 have no effect.
- R3: Offsets 0x0C and 0x10, and every offset that no register maps to, read as zero. Writes to them change no register.
- R4: An access at offset 0x00 or 0x03 is a data register access, whether it is a read or a write.
- R5: A byte offered on rx_valid_i is stored only while control bit 0 (receive enable) is set. Status bit 0 (data ready) is set while unread bytes remain.
- R6: Data register reads return bytes in arrival order, and each read removes one byte. The read that takes the last byte clears status bit 0. A read of an empty buffer returns 0.
- R7: rx_ready_o goes low once DEPTH bytes have been stored since the buffer was last empty, even if some of them have been read. When the buffer is read empty it restarts at slot zero and rx_ready_o returns high.
- R8: A byte offered while receive is enabled and rx_ready_o is low is dropped. It sets status bit 4 (overrun), which stays set until reset.
- R9: A data register write while control bit 1 (transmit enable) is set raises tx_valid_o for exactly one cycle after the access, with tx_data_o equal to the low 8 bits written. With the bit clear, no strobe is made.
- R10: irq_o pulses for one cycle after a stored receive byte if control bit 2 is set, and after a sent transmit byte if control bit 3 is set. Otherwise it stays low.
- R11: Status bit 8 is set while the unread count is at least DEPTH/2. Status bit 10 is set while rx_ready_o is low. Status bits 1 and 2 always read 1.
- R12: pready_o is high and pslverr_o is low on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | 8 | APB byte offset into the window |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, valid in the access phase |
| pready_o | output | 1 | APB ready, always high |
| pslverr_o | output | 1 | APB error, always low |
| rx_valid_i | input | 1 | Receiver offers a byte this cycle |
| rx_data_i | input | 8 | Offered receive byte |
| rx_ready_o | output | 1 | Buffer has a free slot |
| tx_valid_o | output | 1 | One-cycle strobe for a byte to send |
| tx_data_o | output | 8 | Byte to send |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with DEPTH = 4. With that depth the full buffer, the half-full status bit, overrun and the rule that freed slots stay unusable until the buffer is empty are all reached within a handful of receive strokes. The default depth is 16 and would only lengthen those sequences. At DEPTH = 4 the half threshold is two bytes, so the bench can see the bit both set and cleared between single reads.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int OFF_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL
  } reg_sel_e;

  localparam logic [OFF_W-1:0] OFF_DATA   = 8'h00;
  localparam logic [OFF_W-1:0] OFF_DATA_B = 8'h03;
  localparam logic [OFF_W-1:0] OFF_STAT   = 8'h04;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 8'h08;

  localparam int CTRL_RX_EN = 0;
  localparam int CTRL_TX_EN = 1;
  localparam int CTRL_RX_IE = 2;
  localparam int CTRL_TX_IE = 3;

  localparam int ST_DREADY = 0;
  localparam int ST_TSHIFT = 1;
  localparam int ST_TEMPTY = 2;
  localparam int ST_OVR    = 4;
  localparam int ST_RHALF  = 8;
  localparam int ST_RFULL  = 10;
endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_regs_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  output reg_sel_e         sel_o
);
  always_comb begin
    unique case (off_i)
      OFF_DATA, OFF_DATA_B: sel_o = SEL_DATA;
      OFF_STAT:             sel_o = SEL_STAT;
      OFF_CTRL:             sel_o = SEL_CTRL;
      default:              sel_o = SEL_NONE;  // scaler, debug, unmapped
    endcase
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              half_o
);
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LEN_W-1:0]  len_q, rd_q, unread;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              pop_ok, drain;
  logic [IDX_W-1:0]  wr_idx;

  assign unread  = len_q - rd_q;
  assign empty_o = (unread == '0);
  assign full_o  = (len_q == LEN_W'(DEPTH));
  assign half_o  = (unread >= LEN_W'(DEPTH / 2));
  assign pop_ok  = pop_i && !empty_o;
  // the pop that takes the last byte sends both indices home
  assign drain   = pop_ok && ((rd_q + LEN_W'(1)) == len_q);
  assign wr_idx  = drain ? '0 : len_q[IDX_W-1:0];
  assign head_o  = mem_q[rd_q[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      rd_q  <= '0;
    end else if (drain) begin
      rd_q  <= '0;
      len_q <= push_i ? LEN_W'(1) : '0;
    end else begin
      if (pop_ok) rd_q <= rd_q + LEN_W'(1);
      if (push_i) len_q <= len_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_idx] <= push_data_i;
  end
endmodule

// File: rtl/uart_event_out.sv
module uart_event_out (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_fire_i,
  input  logic [7:0] tx_byte_i,
  input  logic       rx_store_i,
  input  logic       rx_ie_i,
  input  logic       tx_ie_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      irq_o      <= 1'b0;
    end else begin
      tx_valid_o <= tx_fire_i;
      if (tx_fire_i) tx_data_o <= tx_byte_i;
      irq_o <= (rx_store_i && rx_ie_i) || (tx_fire_i && tx_ie_i);
    end
  end
endmodule

// File: rtl/uart_apb_regs.sv
module uart_apb_regs
  import uart_regs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psel_i,
  input  logic             penable_i,
  input  logic             pwrite_i,
  input  logic [OFF_W-1:0] paddr_i,
  input  logic [31:0]      pwdata_i,
  output logic [31:0]      prdata_o,
  output logic             pready_o,
  output logic             pslverr_o,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  output logic             rx_ready_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic             irq_o
);
  reg_sel_e    sel;
  logic        acc, rd_acc, wr_acc;
  logic [31:0] ctrl_q, status_w;
  logic        ovr_q;
  logic        pop, rx_store, tx_fire;
  logic [7:0]  head;
  logic        empty, full, half;

  assign acc       = psel_i && penable_i;
  assign rd_acc    = acc && !pwrite_i;
  assign wr_acc    = acc && pwrite_i;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  uart_reg_decode u_dec (
    .off_i (paddr_i),
    .sel_o (sel)
  );

  assign pop        = rd_acc && (sel == SEL_DATA);
  assign rx_ready_o = !full;
  assign rx_store   = rx_valid_i && !full && ctrl_q[CTRL_RX_EN];
  assign tx_fire    = wr_acc && (sel == SEL_DATA) && ctrl_q[CTRL_TX_EN];

  uart_rx_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_store),
    .push_data_i (rx_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (full),
    .half_o      (half)
  );

  uart_event_out u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_fire_i  (tx_fire),
    .tx_byte_i  (pwdata_i[7:0]),
    .rx_store_i (rx_store),
    .rx_ie_i    (ctrl_q[CTRL_RX_IE]),
    .tx_ie_i    (ctrl_q[CTRL_TX_IE]),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_acc && (sel == SEL_CTRL)) ctrl_q <= pwdata_i;
      if (rx_valid_i && full && ctrl_q[CTRL_RX_EN]) ovr_q <= 1'b1;
    end
  end

  always_comb begin
    status_w            = '0;
    status_w[ST_DREADY] = !empty;
    status_w[ST_TSHIFT] = 1'b1;  // transmit path holds nothing here
    status_w[ST_TEMPTY] = 1'b1;
    status_w[ST_OVR]    = ovr_q;
    status_w[ST_RHALF]  = half;
    status_w[ST_RFULL]  = full;
  end

  always_comb begin
    prdata_o = '0;
    if (rd_acc) begin
      unique case (sel)
        SEL_DATA: prdata_o = empty ? 32'h0 : {24'h0, head};
        SEL_STAT: prdata_o = status_w;
        SEL_CTRL: prdata_o = ctrl_q;
        default:  prdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regs_chk.sv
module uart_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        psel_i,
  input logic        penable_i,
  input logic        pwrite_i,
  input logic [7:0]  paddr_i,
  input logic [31:0] pwdata_i,
  input logic        rx_valid_i,
  input logic        rx_ready_o,
  input logic        tx_valid_o,
  input logic [7:0]  tx_data_o,
  input logic        irq_o,
  input logic [31:0] ctrl_q,
  input logic [31:0] status_w
);
  // R9
  tx_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(psel_i && penable_i && pwrite_i && ctrl_q[1] &&
                         (paddr_i == 8'h00 || paddr_i == 8'h03)) &&
                   tx_data_o == $past(pwdata_i[7:0]));

  // R9
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o);

  // R10
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rx_valid_i && rx_ready_o && ctrl_q[0] && ctrl_q[2]) ||
              (tx_valid_o && $past(ctrl_q[3])));

  // R5
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !ctrl_q[0] && !(psel_i && penable_i)) |=> $stable(status_w));

  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && ctrl_q[0] && !rx_ready_o) |=> status_w[4]);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w[4] |=> status_w[4]);

  // R11
  full_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_o |-> (status_w[10] && status_w[0]));
endmodule

bind uart_apb_regs uart_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .psel_i     (psel_i),
  .penable_i  (penable_i),
  .pwrite_i   (pwrite_i),
  .paddr_i    (paddr_i),
  .pwdata_i   (pwdata_i),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .irq_o      (irq_o),
  .ctrl_q     (ctrl_q),
  .status_w   (status_w)
);

// File: tb/sim_uart_apb_regs.sv
module sim_uart_apb_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 8'h08, 32'hDEADBEEF, 32'h0,        8'd2},  // R2
    '{1'b0, 8'h08, 32'h0,        32'hDEADBEEF, 8'd2},
    '{1'b1, 8'h04, 32'hFFFFFFFF, 32'h0,        8'd2},
    '{1'b0, 8'h04, 32'h0,        32'h00000006, 8'd2},
    '{1'b1, 8'h0C, 32'h00001234, 32'h0,        8'd3},  // R3
    '{1'b0, 8'h0C, 32'h0,        32'h0,        8'd3},
    '{1'b1, 8'h10, 32'h00000055, 32'h0,        8'd3},
    '{1'b0, 8'h10, 32'h0,        32'h0,        8'd3},
    '{1'b0, 8'h14, 32'h0,        32'h0,        8'd3},
    '{1'b0, 8'hFF, 32'h0,        32'h0,        8'd3},
    '{1'b0, 8'h08, 32'h0,        32'hDEADBEEF, 8'd3},
    '{1'b1, 8'h08, 32'h0,        32'h0,        8'd2},
    '{1'b0, 8'h08, 32'h0,        32'h0,        8'd2},
    '{1'b0, 8'h00, 32'h0,        32'h0,        8'd6}   // R6 empty read
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int checks = 0;
  int failures = 0;
  logic [31:0] rd_v;
  logic        tx_v, irq_v, rdy_v, prdy_v, perr_v;
  logic [7:0]  txd_v;
  bit          done = 0;

  uart_apb_regs #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd_v = prdata; prdy_v = pready; perr_v = pslverr;
    @(negedge clk);
    tx_v = tx_valid; txd_v = tx_data; irq_v = irq;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    #1;
    rdy_v = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
    irq_v = irq;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    apb(1'b0, 8'h04, 0); check("R1 status", rd_v, 32'h006);
    apb(1'b0, 8'h08, 0); check("R1 control", rd_v, 32'h0);
    // R12
    check("R12 pready", {31'b0, prdy_v}, 32'h1);
    check("R12 pslverr", {31'b0, perr_v}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      apb(VEC[i].wr, VEC[i].a, VEC[i].d);
      if (!VEC[i].wr) check($sformatf("R%0d vec%0d", VEC[i].req, i), rd_v, VEC[i].exp);
    end

    // R5 receive disabled: byte not stored
    push(8'h11);
    check("R10 no irq when disabled", {31'b0, irq_v}, 32'h0);
    apb(1'b0, 8'h04, 0); check("R5 status rx off", rd_v, 32'h006);

    // rx enable + rx irq enable
    apb(1'b1, 8'h08, 32'h5);
    push(8'hA1);
    check("R10 rx irq pulse", {31'b0, irq_v}, 32'h1);
    @(negedge clk); check("R10 irq one cycle", {31'b0, irq}, 32'h0);
    apb(1'b0, 8'h04, 0); check("R5 data ready", rd_v, 32'h007);
    push(8'hA2);
    apb(1'b0, 8'h04, 0); check("R11 half set", rd_v, 32'h107);
    apb(1'b0, 8'h00, 0); check("R6 first byte", rd_v, 32'hA1);
    apb(1'b0, 8'h04, 0); check("R11 half clear", rd_v, 32'h007);
    apb(1'b0, 8'h03, 0); check("R4 read at 0x03", rd_v, 32'hA2);
    apb(1'b0, 8'h04, 0); check("R6 ready cleared", rd_v, 32'h006);
    apb(1'b0, 8'h00, 0); check("R6 empty read", rd_v, 32'h0);

    // fill to DEPTH
    for (int k = 0; k < DEPTH; k++) push(8'hB0 + 8'(k));
    check("R7 rx_ready low at full", {31'b0, rx_ready}, 32'h0);
    apb(1'b0, 8'h04, 0); check("R11 full status", rd_v, 32'h507);
    push(8'hBF);
    check("R8 dropped byte no irq", {31'b0, irq_v}, 32'h0);
    apb(1'b0, 8'h04, 0); check("R8 overrun", rd_v, 32'h517);
    apb(1'b0, 8'h00, 0); check("R6 order 0", rd_v, 32'hB0);
    #1; check("R7 no reuse before empty", {31'b0, rx_ready}, 32'h0);
    for (int k = 1; k < DEPTH; k++) begin
      apb(1'b0, 8'h00, 0); check("R6 order", rd_v, 32'hB0 + 32'(k));
    end
    #1; check("R7 ready after drain", {31'b0, rx_ready}, 32'h1);
    apb(1'b0, 8'h04, 0); check("R8 overrun sticky", rd_v, 32'h016);
    push(8'hC0);
    apb(1'b0, 8'h00, 0); check("R7 restart", rd_v, 32'hC0);

    // transmit
    apb(1'b1, 8'h08, 32'h0);
    apb(1'b1, 8'h00, 32'h1FF);
    check("R9 no tx when disabled", {31'b0, tx_v}, 32'h0);
    apb(1'b1, 8'h08, 32'h2);
    apb(1'b1, 8'h00, 32'h3C5);
    check("R9 tx strobe", {31'b0, tx_v}, 32'h1);
    check("R9 tx byte", {24'b0, txd_v}, 32'hC5);
    check("R10 no tx irq", {31'b0, irq_v}, 32'h0);
    @(negedge clk); check("R9 strobe one cycle", {31'b0, tx_valid}, 32'h0);
    apb(1'b1, 8'h08, 32'hA);
    apb(1'b1, 8'h03, 32'h77);
    check("R4 write at 0x03", {31'b0, tx_v}, 32'h1);
    check("R9 tx byte 2", {24'b0, txd_v}, 32'h77);
    check("R10 tx irq", {31'b0, irq_v}, 32'h1);

    // R1 reset clears overrun and control
    apb(1'b1, 8'h08, 32'h1);
    push(8'hD0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    apb(1'b0, 8'h04, 0); check("R1 status after reset", rd_v, 32'h006);
    apb(1'b0, 8'h08, 0); check("R1 control after reset", rd_v, 32'h0);

    finish_run();
  end
endmodule